// File: doc/BRIEF.md
# Communication Request Pulse Detector

This block watches the returned level of a sensor output line and looks for a communication request. A request is a sustained level on the line that is the opposite of the level the channel is driving at that moment. The block counts how long the disagreement lasts in microsecond ticks. When the count reaches a programmable threshold, the request is acknowledged and the block emits exactly one fixed-width pulse on its request output.

The pulse polarity is set by a 2-bit channel configuration together with the low bit of the output data. Between pulses the output rests at the idle level, which is the inverse of the pulse level. Request handling needs both the output enable and the request enable. After a pulse, the block accepts no new request until the line has agreed with the driven level again.

Top module: `rcd_request_detector`

## Requirements
- R1: Out of reset, and whenever no pulse is active, `req_out` sits at the idle level. The idle level is the inverse of the pulse level for configurations 11, 10 and 01, and 0 for configuration 00.
- R2: For configuration 11 or 10, the pulse level is 1 when `out_data` is 0, and 0 when `out_data` is 1.
- R3: For configuration 01, the pulse level equals `out_data`: 0 when it is 0, and 1 when it is 1.
- R4: Configuration 00 never produces a pulse, and `req_out` stays 0.
- R5: A request exists while `line_in` differs from `out_data`. Each cycle that has `us_tick` high and a request present adds one to a count. The request is acknowledged on the tick that brings the count to `det_thr`. A request that lasts only `det_thr`-1 ticks is ignored.
- R6: The count restarts from zero as soon as `line_in` equals `out_data` again. Two short requests separated by an idle gap never add up to an acknowledgement.
- R7: An acknowledged request produces exactly one pulse. The pulse starts the cycle after the acknowledging tick and lasts exactly PULSE_US ticks (default 80).
- R8: When `out_en` or `req_en` is 0, no request is counted, no pulse is produced, and `req_out` shows the idle level at once.
- R9: After a pulse, a line that still disagrees with the driven level is not acknowledged again. A new request is accepted only after the line has matched the driven level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| us_tick | input | 1 | One-cycle strobe once per microsecond |
| line_in | input | 1 | Sampled level of the sensor output line |
| out_data | input | 1 | Low bit of the output data (the driven level) |
| cfg | input | 2 | Channel configuration selecting the pulse polarity |
| out_en | input | 1 | Output enable |
| req_en | input | 1 | Request detection enable |
| det_thr | input | THR_W | Detection threshold in microsecond ticks |
| req_out | output | 1 | Request pulse output |

## Verification
The hardest case to reach is a line that keeps disagreeing after the pulse has ended. A badly re-armed detector would then fire a second pulse that only shows up hundreds of cycles later. The stimulus holds the mismatch well beyond the threshold plus the full pulse width, counts output toggles over the whole window, and then follows with a fresh request to show that the block re-arms after an idle gap. The threshold boundary uses requests exactly `det_thr`-1 and `det_thr` ticks long. Because the tick period is fixed, every window of that length holds a known number of ticks, whatever the phase.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_PULSE = 2'd1,
    ST_HOLD  = 2'd2
  } rcd_state_e;

  localparam logic [1:0] CFG_OFF = 2'b00;
  localparam logic [1:0] CFG_INV = 2'b01;

endpackage

// File: rtl/rcd_polarity.sv
module rcd_polarity
  import rcd_pkg::*;
(
  input  logic [1:0] cfg,
  input  logic       out_data,
  output logic       pol_valid,
  output logic       pulse_lvl,
  output logic       idle_lvl
);

  always_comb begin
    pol_valid = (cfg != CFG_OFF);
    if (cfg == CFG_INV) begin
      pulse_lvl = out_data;
    end else begin
      pulse_lvl = ~out_data;
    end
    idle_lvl = pol_valid ? ~pulse_lvl : 1'b0;
  end

endmodule

// File: rtl/rcd_tick_counter.sv
module rcd_tick_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (clr) begin
      cnt_nxt = '0;
    end else if (inc) begin
      cnt_nxt = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || inc) begin
      cnt <= cnt_nxt;
    end
  end

endmodule

// File: rtl/rcd_fsm.sv
module rcd_fsm
  import rcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       mismatch,
  input  logic       ack,
  input  logic       pulse_done,
  output rcd_state_e state
);

  rcd_state_e state_nxt;

  always_comb begin
    state_nxt = state;
    if (!en) begin
      state_nxt = ST_ARMED;
    end else begin
      unique case (state)
        ST_ARMED: if (ack)        state_nxt = ST_PULSE;
        ST_PULSE: if (pulse_done) state_nxt = ST_HOLD;
        ST_HOLD:  if (!mismatch)  state_nxt = ST_ARMED;
        default:                  state_nxt = ST_ARMED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_ARMED;
    end else begin
      state <= state_nxt;
    end
  end

endmodule

// File: rtl/rcd_request_detector.sv
module rcd_request_detector
  import rcd_pkg::*;
#(
  parameter int THR_W    = 8,
  parameter int PULSE_US = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic             line_in,
  input  logic             out_data,
  input  logic [1:0]       cfg,
  input  logic             out_en,
  input  logic             req_en,
  input  logic [THR_W-1:0] det_thr,
  output logic             req_out
);

  localparam int PW_W = $clog2(PULSE_US + 1);
  localparam logic [PW_W-1:0] PW_LAST = PW_W'(PULSE_US - 1);

  logic             pol_valid, pulse_lvl, idle_lvl;
  logic             en, mismatch, ack, pulse_done, pulse_active;
  logic             det_clr, pw_clr;
  logic [THR_W-1:0] det_cnt;
  logic [THR_W:0]   det_sum;
  logic [PW_W-1:0]  pw_cnt;
  logic             lvl_q;
  rcd_state_e       state;

  rcd_polarity u_pol (
    .cfg      (cfg),
    .out_data (out_data),
    .pol_valid(pol_valid),
    .pulse_lvl(pulse_lvl),
    .idle_lvl (idle_lvl)
  );

  assign en       = out_en & req_en & pol_valid;
  assign mismatch = line_in ^ out_data;

  // duration of the current disagreement, in ticks
  assign det_clr = !en || !mismatch || (state != ST_ARMED);
  assign det_sum = {1'b0, det_cnt} + 1'b1;
  assign ack     = en && (state == ST_ARMED) && mismatch && us_tick &&
                   (det_sum >= {1'b0, det_thr});

  rcd_tick_counter #(.W(THR_W)) u_det_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (det_clr),
    .inc  (us_tick),
    .cnt  (det_cnt)
  );

  // width of the pulse being emitted, in ticks
  assign pw_clr     = (state != ST_PULSE);
  assign pulse_done = (state == ST_PULSE) && us_tick && (pw_cnt == PW_LAST);

  rcd_tick_counter #(.W(PW_W)) u_pw_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (pw_clr),
    .inc  (us_tick),
    .cnt  (pw_cnt)
  );

  rcd_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .mismatch  (mismatch),
    .ack       (ack),
    .pulse_done(pulse_done),
    .state     (state)
  );

  // polarity is frozen for the whole pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else if (ack) begin
      lvl_q <= pulse_lvl;
    end
  end

  assign pulse_active = en && (state == ST_PULSE);
  assign req_out      = pulse_active ? lvl_q : idle_lvl;

endmodule

// File: rtl/rcd_checker.sv
module rcd_checker #(
  parameter int PULSE_US = 80
) (
  input logic       clk,
  input logic       rst_n,
  input logic       us_tick,
  input logic       line_in,
  input logic       out_data,
  input logic [1:0] cfg,
  input logic       out_en,
  input logic       req_en,
  input logic       req_out,
  input logic       pulse_active
);

  localparam int CW = $clog2(PULSE_US + 2);

  logic          enabled;
  logic          differ;
  logic [CW-1:0] wticks;
  logic          seen_match;

  assign enabled = out_en && req_en && (cfg != 2'b00);
  assign differ  = (line_in != out_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wticks <= '0;
    end else if (!pulse_active) begin
      wticks <= '0;
    end else if (us_tick) begin
      wticks <= wticks + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_match <= 1'b1;
    end else if (pulse_active) begin
      seen_match <= 1'b0;
    end else if (!differ || !enabled) begin
      seen_match <= 1'b1;
    end
  end

  assert_idle_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(out_en && req_en) && cfg != 2'b00) |-> (req_out == ((cfg == 2'b01) ? ~out_data : out_data)));

  assert_cfg_off_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == 2'b00) |-> (!req_out && !pulse_active));

  assert_ack_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_active) |-> $past(us_tick && differ));

  assert_width_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_active && us_tick) |-> (wticks < CW'(PULSE_US)));

  assert_rearm_after_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_active) |-> $past(seen_match));

endmodule

bind rcd_request_detector rcd_checker #(.PULSE_US(PULSE_US)) u_rcd_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .us_tick     (us_tick),
  .line_in     (line_in),
  .out_data    (out_data),
  .cfg         (cfg),
  .out_en      (out_en),
  .req_en      (req_en),
  .req_out     (req_out),
  .pulse_active(pulse_active)
);

// File: tb/test_rcd_request_detector.sv
module test_rcd_request_detector;

  localparam int THR_W    = 8;
  localparam int PULSE_US = 80;
  localparam int TDIV     = 4;
  localparam int THR      = 10;
  localparam int PULSE_CY = PULSE_US * TDIV;

  logic             clk;
  logic             rst_n;
  logic             us_tick;
  logic             line_in;
  logic             out_data;
  logic [1:0]       cfg;
  logic             out_en;
  logic             req_en;
  logic [THR_W-1:0] det_thr;
  logic             req_out;

  int n_checks;
  int n_fail;
  int tick_ph;

  rcd_request_detector #(.THR_W(THR_W), .PULSE_US(PULSE_US)) i_rcd_request_detector (
    .clk    (clk),
    .rst_n  (rst_n),
    .us_tick(us_tick),
    .line_in(line_in),
    .out_data(out_data),
    .cfg    (cfg),
    .out_en (out_en),
    .req_en (req_en),
    .det_thr(det_thr),
    .req_out(req_out)
  );

  // fields: cfg[4:3], out_data[2], expected idle[1], expected acknowledge[0]
  localparam logic [4:0] VEC [8] = '{
    {2'b11, 1'b0, 1'b0, 1'b1},
    {2'b11, 1'b1, 1'b1, 1'b1},
    {2'b10, 1'b0, 1'b0, 1'b1},
    {2'b10, 1'b1, 1'b1, 1'b1},
    {2'b01, 1'b0, 1'b1, 1'b1},
    {2'b01, 1'b1, 1'b0, 1'b1},
    {2'b00, 1'b0, 1'b0, 1'b0},
    {2'b00, 1'b1, 1'b0, 1'b0}
  };

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  initial begin
    us_tick = 1'b0;
    tick_ph = 0;
    forever begin
      @(negedge clk);
      tick_ph = (tick_ph + 1) % TDIV;
      us_tick = (tick_ph == 0);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    finish_run();
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic idle_of(input logic [1:0] c, input logic d);
    if (c == 2'b00) return 1'b0;
    if (c == 2'b01) return ~d;
    return d;
  endfunction

  // drives a mismatch for hold_t ticks, observes obs_t ticks in total
  task automatic run_req(input int hold_t, input int obs_t, output int act, output int tog);
    logic idl, prev;
    idl  = idle_of(cfg, out_data);
    act  = 0;
    tog  = 0;
    prev = idl;
    for (int i = 0; i < obs_t * TDIV; i++) begin
      @(negedge clk);
      if (req_out != idl) act++;
      if (req_out != prev) tog++;
      prev    = req_out;
      line_in = (i < hold_t * TDIV) ? ~out_data : out_data;
    end
    @(negedge clk);
    line_in = out_data;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int act, tog;
    n_checks = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    cfg      = 2'b01;
    out_data = 1'b0;
    line_in  = 1'b0;
    out_en   = 1'b1;
    req_en   = 1'b1;
    det_thr  = THR_W'(THR);
    settle(3);
    check("R1 reset idle cfg01", int'(req_out), 1);
    @(negedge clk);
    rst_n = 1'b1;
    settle(2);
    check("R1 idle after reset", int'(req_out), 1);

    // table walk: polarity, idle level and width per configuration
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      cfg      = VEC[v][4:3];
      out_data = VEC[v][2];
      line_in  = VEC[v][2];
      settle(2);
      check("R1 idle level", int'(req_out), int'(VEC[v][1]));
      run_req(THR + 2, 100, act, tog);
      check(VEC[v][0] ? "R2/R3/R7 pulse cycles" : "R4 cfg00 pulse cycles",
            act, VEC[v][0] ? PULSE_CY : 0);
      check(VEC[v][0] ? "R7 single pulse toggles" : "R4 cfg00 toggles",
            tog, VEC[v][0] ? 2 : 0);
      settle(8);
    end

    // threshold boundary, cfg 11 data 0
    @(negedge clk);
    cfg = 2'b11; out_data = 1'b0; line_in = 1'b0;
    settle(8);
    run_req(THR - 1, 40, act, tog);
    check("R5 thr-1 ignored", act, 0);
    settle(8);
    run_req(THR, 100, act, tog);
    check("R5 thr acknowledged", act, PULSE_CY);
    settle(8);

    // counter restart: two short requests separated by a match gap
    run_req(THR - 3, 3, act, tog);
    check("R6 first half", act, 0);
    run_req(THR - 3, 40, act, tog);
    check("R6 restart no ack", act, 0);
    settle(8);

    // enables
    @(negedge clk); out_en = 1'b0;
    run_req(THR + 5, 60, act, tog);
    check("R8 out_en low no pulse", act, 0);
    @(negedge clk); out_en = 1'b1; req_en = 1'b0;
    run_req(THR + 5, 60, act, tog);
    check("R8 req_en low no pulse", act, 0);
    @(negedge clk); req_en = 1'b1;
    settle(8);

    // mid-pulse disable drops to idle at once
    @(negedge clk); line_in = ~out_data;
    settle((THR + 3) * TDIV);
    check("R7 pulse active", int'(req_out), 1);
    req_en = 1'b0;
    #1;
    check("R8 disable idles output", int'(req_out), 0);
    @(negedge clk); line_in = out_data;
    settle(4);
    req_en = 1'b1;
    settle(8);

    // long request: one pulse, then re-arm only after match
    run_req(THR + PULSE_US + 30, THR + PULSE_US + 40, act, tog);
    check("R9 long hold pulse cycles", act, PULSE_CY);
    check("R9 long hold toggles", tog, 2);
    settle(8);
    run_req(THR + 2, 100, act, tog);
    check("R9 re-armed after match", act, PULSE_CY);

    finish_run();
  end

endmodule